// File: doc/BRIEF.md
# Masked Move-Priority Selector

This block picks the next move to try during a search ply. Each of 64 board squares may carry a candidate: a valid bit, the 3-bit value of the piece that would be captured there, and a flag that marks the move as a killer. The block forms a 4-bit priority key for every square. Squares already searched in the current ply are hidden. A six-level binary comparator tree then reduces the 64 entries to one winner in a single combinational pass, with no sequential scan.

An examined-mask register records the squares that have already been searched. The search controller pulses `mark` when it takes the current winner, and that square drops out of the selection from the next cycle on. At the start of every ply, `ply_start` empties the mask. The winner's square, key and a valid flag are outputs with no pipeline stage, so the controller sees a change in the candidates within the same cycle.

Top module: `move_pick_tree`

## Requirements
- R1: When at least one square is valid and not examined, `pick_valid` is 1 and `pick_idx` names a valid, unexamined square whose key is the largest among all such squares.
- R2: The key of square s is `value*2 + killer`, where `value` is bits [3s+2:3s] of `cand_value` and `killer` is bit s of `cand_killer`. Any capture with a value above zero therefore outranks a killer flag alone, and `pick_key` reports the winner's key.
- R3: Among squares with equal keys, the lowest square index wins.
- R4: When no square is both valid and unexamined, `pick_valid`, `pick_idx` and `pick_key` are all zero.
- R5: If `mark` is high at a clock edge while `pick_valid` is 1, the winning square is excluded from the selection from the next cycle on, until the mask is cleared.
- R6: If `ply_start` is high at a clock edge, the mask is empty in the next cycle. This holds even when `mark` is high in the same cycle.
- R7: If `mark` is high while `pick_valid` is 0, no square is excluded, square 0 included.
- R8: Synchronous active-high `rst` empties the mask.
- R9: The outputs follow a change of the candidate inputs within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 64 | Bit s: square s holds a candidate |
| cand_value | input | 192 | 3-bit victim value per square; square s uses bits [3s+2:3s] |
| cand_killer | input | 64 | Bit s: the candidate on square s is a killer move |
| ply_start | input | 1 | Clears the examined mask at the clock edge |
| mark | input | 1 | Marks the current winner as examined at the clock edge |
| pick_valid | output | 1 | A selectable candidate exists |
| pick_idx | output | 6 | Square index of the winner; zero when none |
| pick_key | output | 4 | Key of the winner; zero when none |

## Verification
The two mask operations, clearing for a new ply and marking the current winner, can arrive in the same cycle. The bench raises `ply_start` and `mark` together while a winner is shown. After that edge it expects every square to be selectable again, including the square that was the winner. A related collision is a mark that arrives with no winner at all. The bench drives that case and then shows square 0, to confirm that the zero on `pick_idx` is never written into the mask.

// File: rtl/mvpick_pkg.sv
package mvpick_pkg;
    localparam int SQ_N   = 64;
    localparam int VAL_W  = 3;
    localparam int IDX_W  = $clog2(SQ_N);
    localparam int KEY_W  = VAL_W + 1;
    localparam int LVL_N  = IDX_W;

    typedef struct packed {
        logic             live;
        logic [KEY_W-1:0] key;
        logic [IDX_W-1:0] sq;
    } cand_t;

    // Victim value dominates; the killer flag only breaks ties in value.
    function automatic logic [KEY_W-1:0] make_key(logic [VAL_W-1:0] v, logic k);
        return {v, k};
    endfunction

    // lo always carries the lower square indices, so it wins on equal keys.
    function automatic cand_t pick_pair(cand_t lo, cand_t hi);
        if (!hi.live) return lo;
        if (!lo.live) return hi;
        if (hi.key > lo.key) return hi;
        return lo;
    endfunction
endpackage

// File: rtl/mvpick_leaves.sv
module mvpick_leaves
    import mvpick_pkg::*;
(
    input  logic [SQ_N-1:0]       cand_valid,
    input  logic [SQ_N*VAL_W-1:0] cand_value,
    input  logic [SQ_N-1:0]       cand_killer,
    input  logic [SQ_N-1:0]       done_mask,
    output cand_t                 leaf [SQ_N]
);
    for (genvar s = 0; s < SQ_N; s++) begin : g_sq
        assign leaf[s].live = cand_valid[s] & ~done_mask[s];
        assign leaf[s].key  = make_key(cand_value[s*VAL_W +: VAL_W], cand_killer[s]);
        assign leaf[s].sq   = IDX_W'(s);
    end
endmodule

// File: rtl/mvpick_tree.sv
module mvpick_tree
    import mvpick_pkg::*;
(
    input  cand_t leaf [SQ_N],
    output cand_t win
);
    for (genvar l = 0; l <= LVL_N; l++) begin : lv
        localparam int W = SQ_N >> l;
        cand_t v [W];
        if (l == 0) begin : g_in
            for (genvar s = 0; s < W; s++) begin : g_s
                assign v[s] = leaf[s];
            end
        end else begin : g_cmp
            for (genvar n = 0; n < W; n++) begin : g_n
                assign v[n] = pick_pair(lv[l-1].v[2*n], lv[l-1].v[2*n+1]);
            end
        end
    end

    assign win = lv[LVL_N].v[0];
endmodule

// File: rtl/mvpick_mask.sv
module mvpick_mask
    import mvpick_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ply_start,
    input  logic             mark,
    input  logic             win_live,
    input  logic [IDX_W-1:0] win_sq,
    output logic [SQ_N-1:0]  done_mask
);
    always_ff @(posedge clk) begin
        if (rst || ply_start) begin
            done_mask <= '0;
        end else if (mark && win_live) begin
            done_mask[win_sq] <= 1'b1;
        end
    end
endmodule

// File: rtl/move_pick_tree.sv
module move_pick_tree
    import mvpick_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SQ_N-1:0]       cand_valid,
    input  logic [SQ_N*VAL_W-1:0] cand_value,
    input  logic [SQ_N-1:0]       cand_killer,
    input  logic                  ply_start,
    input  logic                  mark,
    output logic                  pick_valid,
    output logic [IDX_W-1:0]      pick_idx,
    output logic [KEY_W-1:0]      pick_key
);
    logic [SQ_N-1:0] done_mask;
    cand_t           leaf [SQ_N];
    cand_t           win;

    mvpick_leaves i_leaves (
        .cand_valid (cand_valid),
        .cand_value (cand_value),
        .cand_killer(cand_killer),
        .done_mask  (done_mask),
        .leaf       (leaf)
    );

    mvpick_tree i_tree (
        .leaf(leaf),
        .win (win)
    );

    mvpick_mask i_mask (
        .clk      (clk),
        .rst      (rst),
        .ply_start(ply_start),
        .mark     (mark),
        .win_live (win.live),
        .win_sq   (win.sq),
        .done_mask(done_mask)
    );

    assign pick_valid = win.live;
    assign pick_idx   = win.live ? win.sq  : '0;
    assign pick_key   = win.live ? win.key : '0;
endmodule

// File: rtl/move_pick_tree_chk.sv
module move_pick_tree_chk
    import mvpick_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ply_start,
    input logic             mark,
    input logic [SQ_N-1:0]  cand_valid,
    input logic             pick_valid,
    input logic [IDX_W-1:0] pick_idx,
    input logic [KEY_W-1:0] pick_key,
    input logic [SQ_N-1:0]  done_mask
);
    a_r4_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !pick_valid |-> (pick_idx == '0 && pick_key == '0));

    a_r4_none_selectable: assert property (@(posedge clk) disable iff (rst)
        ((cand_valid & ~done_mask) == '0) |-> !pick_valid);

    a_r1_pick_is_live: assert property (@(posedge clk) disable iff (rst)
        pick_valid |-> (cand_valid[pick_idx] && !done_mask[pick_idx]));

    a_r5_mark_sets: assert property (@(posedge clk) disable iff (rst)
        (mark && pick_valid && !ply_start) |=> done_mask[$past(pick_idx)]);

    a_r5_mask_grows: assert property (@(posedge clk) disable iff (rst)
        !ply_start |=> (($past(done_mask) & ~done_mask) == '0));

    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        ply_start |=> (done_mask == '0));

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!ply_start && !(mark && pick_valid)) |=> $stable(done_mask));
endmodule

bind move_pick_tree move_pick_tree_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .ply_start (ply_start),
    .mark      (mark),
    .cand_valid(cand_valid),
    .pick_valid(pick_valid),
    .pick_idx  (pick_idx),
    .pick_key  (pick_key),
    .done_mask (done_mask)
);

// File: tb/test_move_pick_tree.sv
module test_move_pick_tree;
    import mvpick_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                  rst;
    logic [SQ_N-1:0]       cand_valid;
    logic [SQ_N*VAL_W-1:0] cand_value;
    logic [SQ_N-1:0]       cand_killer;
    logic                  ply_start;
    logic                  mark;
    logic                  pick_valid;
    logic [IDX_W-1:0]      pick_idx;
    logic [KEY_W-1:0]      pick_key;

    move_pick_tree i_move_pick_tree (
        .clk        (clk),
        .rst        (rst),
        .cand_valid (cand_valid),
        .cand_value (cand_value),
        .cand_killer(cand_killer),
        .ply_start  (ply_start),
        .mark       (mark),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx),
        .pick_key   (pick_key)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference state: the set of examined squares, kept as a bit list.
    logic [SQ_N-1:0] m_mask;
    bit m_ev;
    int m_idx;
    int m_key;

    task automatic model();
        m_ev  = 1'b0;
        m_idx = 0;
        m_key = 0;
        for (int s = 0; s < SQ_N; s++) begin
            if (cand_valid[s] && !m_mask[s]) begin
                int k;
                k = int'(cand_value[s*VAL_W +: VAL_W]) * 2 + int'(cand_killer[s]);
                if (!m_ev || k > m_key) begin
                    m_ev  = 1'b1;
                    m_idx = s;
                    m_key = k;
                end
            end
        end
    endtask

    task automatic check(string tag);
        model();
        n_chk++;
        if (pick_valid !== m_ev || int'(pick_idx) != m_idx || int'(pick_key) != m_key) begin
            n_bad++;
            $display("FAIL %s: got valid=%0d idx=%0d key=%0d, expected valid=%0d idx=%0d key=%0d",
                     tag, pick_valid, pick_idx, pick_key, m_ev, m_idx, m_key);
        end
    endtask

    task automatic cyc(string tag);
        #1;
        check(tag);
        @(posedge clk);
        if (rst || ply_start) m_mask = '0;
        else if (mark && m_ev) m_mask[m_idx] = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_all(logic [VAL_W-1:0] v);
        for (int s = 0; s < SQ_N; s++) cand_value[s*VAL_W +: VAL_W] = v;
    endtask

    initial begin
        rst = 1'b1; ply_start = 1'b0; mark = 1'b0;
        cand_valid = '0; cand_killer = '0; cand_value = '0;
        m_mask = '0;
        @(negedge clk);
        cyc("R8");
        rst = 1'b0;

        // Reset state: every valid square selectable, equal keys.
        cand_valid = '1; set_all(3'd2);
        cyc("R8");

        // Mark every square in turn: lowest index first, each one then hidden.
        mark = 1'b1;
        for (int i = 0; i < SQ_N; i++) cyc("R5");
        // Nothing left: mark must not hide square 0 or anything else.
        cyc("R7");
        cyc("R4");

        // Clear and mark in the same cycle: clear wins.
        ply_start = 1'b1;
        cyc("R6");
        ply_start = 1'b0;
        cyc("R6");
        mark = 1'b0;
        cyc("R6");

        // Mark a few squares, then reset restores them.
        mark = 1'b1;
        repeat (3) cyc("R5");
        mark = 1'b0;
        rst = 1'b1;
        cyc("R8");
        rst = 1'b0;
        cyc("R8");

        // Key order: value above killer.
        cand_valid = '0; cand_value = '0; cand_killer = '0;
        cand_valid[2] = 1'b1; cand_killer[2] = 1'b1;
        cand_valid[5] = 1'b1; cand_value[5*VAL_W +: VAL_W] = 3'd1;
        cyc("R2");
        cand_valid[9] = 1'b1; cand_value[9*VAL_W +: VAL_W] = 3'd1; cand_killer[9] = 1'b1;
        cyc("R2");
        cand_valid[60] = 1'b1; cand_value[60*VAL_W +: VAL_W] = 3'd7;
        cyc("R1");

        // Ties resolve to the lowest index.
        cand_valid = '0; cand_killer = '0; set_all(3'd4);
        for (int s = 40; s < SQ_N; s++) cand_valid[s] = 1'b1;
        cyc("R3");
        cand_killer[50] = 1'b1; cand_killer[45] = 1'b1;
        cyc("R3");

        // No candidates, with and without mark.
        cand_valid = '0;
        cyc("R4");
        mark = 1'b1;
        cyc("R7");
        mark = 1'b0;
        cand_valid[0] = 1'b1;
        cyc("R7");

        // Same-cycle response to input changes.
        cand_valid[33] = 1'b1; cand_value[33*VAL_W +: VAL_W] = 3'd6;
        #1; check("R9");
        cand_killer[0] = 1'b1; cand_value[0] = 1'b0; cand_value[2:1] = 2'b11;
        #1; check("R9");
        cyc("R9");

        // Random patterns with random marks and occasional ply starts.
        for (int it = 0; it < 400; it++) begin
            for (int s = 0; s < SQ_N; s++) begin
                cand_valid[s]  = ($urandom_range(3) != 0);
                cand_killer[s] = ($urandom_range(7) == 0);
                cand_value[s*VAL_W +: VAL_W] = 3'($urandom_range(7));
            end
            mark      = ($urandom_range(1) == 1);
            ply_start = ($urandom_range(15) == 0);
            cyc("R1");
        end
        mark = 1'b0; ply_start = 1'b0;
        cyc("R1");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got no end of run, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule